// File: doc/BRIEF.md
# Directory Sharer-Tracking Entry Controller

This block keeps the coherence directory entry of one 512-bit memory line. Protecting the whole line with a single 11-bit check code, in place of 8 check bits for every 64-bit word, frees 53 bits. The entry lives in those bits. On each accepted request the controller decodes the stored entry and applies one operation: add a sharer, make a node the exclusive owner, drop a sharer, clear, or start an invalidation. It then returns the re-encoded entry for write-back.

The sharer field is 40 bits. It normally holds up to four exact 10-bit node pointers. When a fifth distinct sharer arrives, the field becomes a coarse vector: each bit stands for a run of 26 consecutive node IDs, and every existing pointer is folded into the vector in the same step. An invalidate request emits its targets one per cycle on a valid/ready port. In pointer form the targets are node IDs. In vector form they are group indices. Each one-to-many invalidation is therefore bounded by 40 messages.

The entry uses bits [44:0] of the 53-bit spare field:

| Bits | Field |
|------|-------|
| [1:0] | state: 00 uncached, 01 shared, 10 exclusive, 11 reserved |
| [2] | format: 0 pointers, 1 coarse vector |
| [4:3] | pointer count minus one |
| [44:5] | sharer field: pointer slot k in bits [5+10k +: 10], or vector bit g in bit 5+g |

Top module: `dir_entry_ctrl`

## Requirements
- R1: Bits [52:45] of `entry_out` are always zero, and bits [52:45] of `entry_in` have no effect on any result. Pointer slots that are not in use are written as zero.
- R2: Operation code 000 (add sharer) on a pointer-form entry works as follows. An uncached entry becomes shared with the node in slot 0 and a count field of 0. An exclusive entry becomes shared, and its owner is kept in slot 0. A new distinct node is appended in the next ascending slot, and the count field is incremented. A node already held in a slot leaves the entry unchanged.
- R3: Adding a fifth distinct node to a shared entry that holds four pointers produces a shared coarse-vector entry (format 1, count 0). In that entry, bit node/26 is set for the new node and for all four old pointers, and no other bit is set.
- R4: Adding a node to a coarse-vector entry sets bit node/26 and keeps every bit already set.
- R5: Operation code 001 (set owner) from any valid state produces an exclusive pointer-form entry. The node is in slot 0, the count field is 0 and every other sharer bit is 0.
- R6: Operation code 010 (remove sharer) in pointer form behaves as follows. A matching pointer is removed, the higher slots shift down one place, and the count field is decremented. Removing the only pointer, whether in shared or exclusive state, yields the all-zero uncached entry. A node that is not present leaves the entry unchanged.
- R7: Removing a node from a coarse-vector entry leaves the entry unchanged.
- R8: Operation code 011 (clear) produces the all-zero entry, which is uncached and in pointer form.
- R9: A stored state of 11, or an operation code of 101, 110 or 111, raises `err` with the result. The returned entry then equals bits [44:0] of `entry_in`, and no invalidation starts.
- R10: An accepted request (`req_valid` high with `req_ready` high) produces `res_valid` high for exactly one cycle, on the next clock edge, together with `entry_out` and `err`.
- R11: Operation code 100 (invalidate) returns the entry unchanged and then presents one target per handshake. For a pointer form entry the targets are the valid slots from slot 0 upward, with `inv_group` low. For a vector form entry the targets are the set bit indices from lowest to highest, with `inv_group` high. `inv_last` marks the final target. An uncached entry yields no targets. While `inv_ready` is low, the presented target holds steady.
- R12: While targets remain to be sent, `req_ready` is low and requests are ignored: no `res_valid` is produced.
- R13: After reset, `req_ready` is high, and `res_valid`, `err`, `inv_valid` and `entry_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 3 | Operation code |
| req_node | input | 10 | Node the operation refers to |
| entry_in | input | 53 | Spare check-bit field as read from memory |
| res_valid | output | 1 | One-cycle strobe for the result |
| entry_out | output | 53 | Re-encoded spare field for write-back |
| err | output | 1 | Reserved state or unknown operation |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Consumer takes the target |
| inv_target | output | 10 | Node ID or group index |
| inv_group | output | 1 | Target is a coarse group index |
| inv_last | output | 1 | Final target of this invalidation |

## Verification
The result of a request is registered once. `res_valid`, `entry_out` and `err` are therefore due at the first rising edge after acceptance. The bench drives each request on a falling edge and checks the result on the next falling edge, then checks that `res_valid` has dropped one cycle later. The first invalidation target is visible in the same cycle as the result, and each handshake at a rising edge moves the target to the next one. The bench therefore checks one target per falling edge, and holds `inv_ready` low for a cycle to confirm the target stays stable and that a request made while targets remain produces no result.

// File: rtl/dir_entry_ctrl.sv
module dir_entry_ctrl #(
  parameter int NODE_W = 10,
  parameter int NPTR   = 4,
  parameter int VEC_W  = 40,
  parameter int LINE_SPARE = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LINE_SPARE-1:0] entry_in,
  output logic              res_valid,
  output logic [LINE_SPARE-1:0] entry_out,
  output logic              err,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [NODE_W-1:0] inv_target,
  output logic              inv_group,
  output logic              inv_last
);
  localparam int CNT_W = $clog2(NPTR);
  localparam int ENT_W = 3 + CNT_W + VEC_W;
  localparam int GRP   = ((1 << NODE_W) + VEC_W - 1) / VEC_W;
  localparam int IDX_W = $clog2(VEC_W);
  localparam logic [1:0] ST_UNC = 2'b00, ST_SHR = 2'b01, ST_EXC = 2'b10, ST_RES = 2'b11;
  localparam logic [2:0] OP_ADD = 3'd0, OP_OWN = 3'd1, OP_DEL = 3'd2, OP_CLR = 3'd3, OP_INV = 3'd4;

  typedef logic [NPTR-1:0][NODE_W-1:0] ptrs_t;

  function automatic logic [IDX_W-1:0] grp_of(input logic [NODE_W-1:0] n);
    return IDX_W'(int'(n) / GRP);
  endfunction

  function automatic logic [ENT_W-1:0] pk(input logic [1:0] s, input logic f,
                                          input logic [CNT_W-1:0] c, input logic [VEC_W-1:0] i);
    return {i, c, f, s};
  endfunction

  logic [ENT_W-1:0] cur;
  assign cur = entry_in[ENT_W-1:0];
  wire [1:0]       st     = cur[1:0];
  wire             coarse = (st == ST_SHR) && cur[2];
  wire [VEC_W-1:0] info   = cur[ENT_W-1 -: VEC_W];
  ptrs_t ptr;
  assign ptr = info;
  wire bad = (st == ST_RES) || (req_op > OP_INV);

  logic [CNT_W:0] nv;
  assign nv = (st == ST_SHR && !cur[2]) ? (CNT_W+1)'(cur[2+CNT_W:3]) + 1'b1 :
              (st == ST_EXC) ? (CNT_W+1)'(1) : '0;

  logic             hit;
  logic [CNT_W-1:0] hidx;
  ptrs_t            live, ins, cp;
  logic [VEC_W-1:0] fv, cv, pmask;
  logic [ENT_W-1:0] nxt;

  always_comb begin
    int j;
    hit = 1'b0; hidx = '0; live = '0; cp = '0; fv = '0; pmask = '0; j = 0;
    for (int k = 0; k < NPTR; k++) begin
      if (k < int'(nv)) begin
        live[k] = ptr[k];
        pmask[k] = 1'b1;
        fv[grp_of(ptr[k])] = 1'b1;
        if (!hit && ptr[k] == req_node) begin
          hit = 1'b1;
          hidx = CNT_W'(k);
        end
      end
    end
    for (int k = 0; k < NPTR; k++) begin
      if (k < int'(nv) && !(hit && hidx == CNT_W'(k))) begin
        cp[CNT_W'(j)] = ptr[k];
        j++;
      end
    end
    fv[grp_of(req_node)] = 1'b1;
    cv = info;
    cv[grp_of(req_node)] = 1'b1;
    ins = live;
    if (int'(nv) < NPTR) ins[nv[CNT_W-1:0]] = req_node;

    nxt = cur;
    if (!bad) begin
      case (req_op)
        OP_ADD:
          if (coarse)                 nxt = pk(ST_SHR, 1'b1, '0, cv);
          else if (hit)               nxt = pk(ST_SHR, 1'b0, CNT_W'(nv - 1'b1), live);
          else if (int'(nv) < NPTR)   nxt = pk(ST_SHR, 1'b0, nv[CNT_W-1:0], ins);
          else                        nxt = pk(ST_SHR, 1'b1, '0, fv);
        OP_OWN: nxt = pk(ST_EXC, 1'b0, '0, VEC_W'(req_node));
        OP_DEL:
          if (!coarse && hit) begin
            if (nv == 1) nxt = '0;
            else         nxt = pk(ST_SHR, 1'b0, CNT_W'(nv - 2'd2), cp);
          end
        OP_CLR:  nxt = '0;
        default: nxt = cur;
      endcase
    end
  end

  logic [ENT_W-1:0] ent_q;
  logic [VEC_W-1:0] pend, w_info;
  logic             w_grp;
  logic [IDX_W-1:0] low;
  ptrs_t            wp;
  wire              take = req_valid && req_ready;

  always_comb begin
    low = '0;
    for (int k = VEC_W - 1; k >= 0; k--) if (pend[k]) low = IDX_W'(k);
  end

  assign wp         = w_info;
  assign req_ready  = ~|pend;
  assign inv_valid  = |pend;
  assign inv_group  = w_grp;
  assign inv_target = w_grp ? NODE_W'(low) : wp[low[CNT_W-1:0]];
  assign inv_last   = inv_valid && ((pend & (pend - 1'b1)) == '0);
  assign entry_out  = {{(LINE_SPARE-ENT_W){1'b0}}, ent_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      ent_q     <= '0;
      err       <= 1'b0;
      pend      <= '0;
      w_info    <= '0;
      w_grp     <= 1'b0;
    end else begin
      res_valid <= take;
      if (take) begin
        ent_q <= nxt;
        err   <= bad;
        if (req_op == OP_INV && !bad) begin
          pend   <= coarse ? info : pmask;
          w_info <= info;
          w_grp  <= coarse;
        end
      end else if (inv_valid && inv_ready) begin
        pend[low] <= 1'b0;
      end
    end
  end
endmodule

module dir_entry_ctrl_chk #(
  parameter int NODE_W = 10,
  parameter int LINE_SPARE = 53,
  parameter int ENT_W = 45
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic [LINE_SPARE-1:0] entry_in,
  input logic res_valid,
  input logic [LINE_SPARE-1:0] entry_out,
  input logic err,
  input logic inv_valid,
  input logic inv_ready,
  input logic [NODE_W-1:0] inv_target,
  input logic inv_group,
  input logic inv_last
);
  a_r10_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid || $past(req_valid && req_ready));
  a_r9_err_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready ##1 err |-> entry_out[ENT_W-1:0] == $past(entry_in[ENT_W-1:0]));
  a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_target) && $stable(inv_group) && $stable(inv_last));
  a_r11_last_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready && inv_last |=> !inv_valid);
  a_r12_no_result_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !res_valid);
  a_r3_vector_only_shared: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !err && entry_out[2] |-> entry_out[1:0] == 2'b01);
endmodule

bind dir_entry_ctrl dir_entry_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .entry_in(entry_in), .res_valid(res_valid), .entry_out(entry_out), .err(err),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_target(inv_target),
  .inv_group(inv_group), .inv_last(inv_last)
);

// File: tb/dir_entry_ctrl_tb.sv
`timescale 1ns/1ps
module dir_entry_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, res_valid, err, inv_valid, inv_ready = 1'b0;
  logic inv_group, inv_last;
  logic [2:0] req_op = '0;
  logic [9:0] req_node = '0, inv_target;
  logic [52:0] entry_in = '0, entry_out;
  int total = 0, bad_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dir_entry_ctrl u_dut (.*);

  function automatic [44:0] E(input [1:0] s, input f, input [1:0] c, input [39:0] i);
    return {i, c, f, s};
  endfunction
  function automatic [39:0] P(input [9:0] a, input [9:0] b, input [9:0] c, input [9:0] d);
    return {d, c, b, a};
  endfunction
  function automatic [115:0] row(input [3:0] rq, input [2:0] op, input [9:0] nd, input [7:0] sp,
                                 input [44:0] ei, input [44:0] ee, input er);
    return {rq, op, nd, sp, ei, ee, er};
  endfunction

  localparam int NV = 22;
  localparam logic [115:0] VECS [NV] = '{
    row(2, 0, 5,   0, E(0,0,0,0), E(1,0,0,P(5,0,0,0)), 0),                // R2 uncached add
    row(2, 0, 7,   0, E(1,0,0,P(5,0,0,0)), E(1,0,1,P(5,7,0,0)), 0),       // R2 append
    row(2, 0, 5,   0, E(1,0,1,P(5,7,0,0)), E(1,0,1,P(5,7,0,0)), 0),       // R2 duplicate
    row(2, 0, 5,   0, E(2,0,0,P(5,0,0,0)), E(1,0,0,P(5,0,0,0)), 0),       // R2 owner re-add
    row(2, 0, 6,   0, E(2,0,0,P(5,0,0,0)), E(1,0,1,P(5,6,0,0)), 0),       // R2 exclusive to shared
    row(3, 0, 900, 0, E(1,0,3,P(1,2,3,4)), E(1,1,0,40'h04_0000_0001), 0), // R3 fold
    row(3, 0, 0,   0, E(1,0,3,P(26,52,1000,77)), E(1,1,0,40'h40_0000_0007), 0), // R3 fold groups
    row(4, 0, 1023,0, E(1,1,0,40'h1), E(1,1,0,40'h80_0000_0001), 0),      // R4 top group
    row(4, 0, 30,  0, E(1,1,0,40'h2), E(1,1,0,40'h2), 0),                 // R4 bit already set
    row(5, 1, 300, 0, E(1,1,0,40'h80_0000_0001), E(2,0,0,P(300,0,0,0)), 0), // R5 from vector
    row(5, 1, 12,  0, E(1,0,2,P(1,2,3,0)), E(2,0,0,P(12,0,0,0)), 0),      // R5 from pointers
    row(6, 2, 7,   0, E(1,0,2,P(5,7,9,0)), E(1,0,1,P(5,9,0,0)), 0),       // R6 middle removal
    row(6, 2, 4,   0, E(1,0,3,P(1,2,3,4)), E(1,0,2,P(1,2,3,0)), 0),       // R6 top slot
    row(6, 2, 1,   0, E(1,0,3,P(1,2,3,4)), E(1,0,2,P(2,3,4,0)), 0),       // R6 slot 0
    row(6, 2, 5,   0, E(1,0,0,P(5,0,0,0)), E(0,0,0,0), 0),                // R6 last sharer
    row(6, 2, 8,   0, E(1,0,1,P(5,7,0,0)), E(1,0,1,P(5,7,0,0)), 0),       // R6 absent
    row(6, 2, 5,   0, E(2,0,0,P(5,0,0,0)), E(0,0,0,0), 0),                // R6 owner removed
    row(7, 2, 33,  0, E(1,1,0,40'h2), E(1,1,0,40'h2), 0),                 // R7 vector kept
    row(8, 3, 0,   8'hA5, E(1,1,0,40'hFF), E(0,0,0,0), 0),                // R8 clear
    row(9, 0, 1,   0, E(3,0,0,P(1,0,0,0)), E(3,0,0,P(1,0,0,0)), 1),       // R9 reserved state
    row(9, 5, 3,   0, E(1,0,0,P(5,0,0,0)), E(1,0,0,P(5,0,0,0)), 1),       // R9 unknown op
    row(1, 0, 9,   8'hFF, E(0,0,0,0), E(1,0,0,P(9,0,0,0)), 0)             // R1 spare ignored
  };

  task automatic chk(input bit ok, input int rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad_n++;
      $display("FAIL R%0d actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic send(input [2:0] op, input [9:0] nd, input [52:0] ei);
    req_valid = 1'b1; req_op = op; req_node = nd; entry_in = ei;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk(input int n, input bit g, input int t0, input int t1, input int t2, input int t3);
    int ts[4];
    ts = '{t0, t1, t2, t3};
    inv_ready = 1'b0;
    @(negedge clk);
    chk(inv_valid && inv_target == 10'(ts[0]), 11, {inv_valid, inv_target}, {1'b1, 10'(ts[0])}); // R11 stall hold
    for (int i = 0; i < n; i++) begin
      chk(inv_valid && inv_target == 10'(ts[i]) && inv_group == g && inv_last == (i == n - 1), 11,
          {inv_valid, inv_group, inv_last, inv_target}, {1'b1, g, i == n - 1, 10'(ts[i])});
      chk(!req_ready, 12, req_ready, 0);
      inv_ready = 1'b1;
      @(negedge clk);
    end
    inv_ready = 1'b0;
    chk(!inv_valid && req_ready, 11, {inv_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad_n++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !err && !inv_valid && entry_out == '0, 13,
        {req_ready, res_valid, err, inv_valid, entry_out}, 57'h100_0000_0000_0000); // R13
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [115:0] r;
      r = VECS[v];
      send(r[111:109], r[108:99], {r[98:91], r[90:46]});
      chk(res_valid && entry_out == {8'b0, r[45:1]} && err == r[0], int'(r[115:112]),
          {res_valid, err, entry_out}, {1'b1, r[0], 8'b0, r[45:1]});
      @(negedge clk);
      chk(!res_valid, 10, res_valid, 0); // R10 single pulse
    end

    // R11 pointer walk with stall
    send(3'd4, 0, {8'h0, E(1,0,2,P(11,22,33,0))});
    chk(res_valid && entry_out == {8'h0, E(1,0,2,P(11,22,33,0))}, 11, entry_out, E(1,0,2,P(11,22,33,0)));
    walk(3, 0, 11, 22, 33, 0);

    // R12 request ignored while a vector walk is pending, then R11 vector walk
    send(3'd4, 0, {8'h0, E(1,1,0,40'h80_0002_0008)});
    req_valid = 1'b1; req_op = 3'd3; entry_in = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!res_valid && !req_ready, 12, {res_valid, req_ready}, 2'b00);
    walk(3, 1, 3, 17, 39, 0);

    // R11 exclusive owner, single target
    send(3'd4, 0, {8'h0, E(2,0,0,P(44,0,0,0))});
    walk(1, 0, 44, 0, 0, 0);

    // R11 uncached yields nothing
    send(3'd4, 0, '0);
    chk(!inv_valid && req_ready, 11, {inv_valid, req_ready}, 2'b01);
    @(negedge clk);
    chk(!inv_valid, 11, inv_valid, 0);

    // R9 reserved state must not start a walk
    send(3'd4, 0, {8'h0, E(3,0,0,P(2,0,0,0))});
    chk(err && !inv_valid, 9, {err, inv_valid}, 2'b10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end
endmodule